// File: doc/BRIEF.md
# Character Display Nibble-Interface Receiver

This block is the display-side front end of a character display controller. It watches a host write strobe, a register-select line and an 8-bit data bus. It turns the writes into complete command or data bytes. The interface can be 8 bits wide, where one strobe carries one byte. It can also be 4 bits wide, where only the upper four bus lines are used and each byte needs two strobes, high nibble first. The width is chosen at run time by the function-set command. The block also decodes the line-count and font bits from that command, and it flags set-address commands.

The nibble phase is kept across idle cycles and host resets. A host that restarts in the middle of a byte therefore leaves a stray high nibble latched, and its next nibble is paired with that stray half. This is the real desync behaviour. A correct host recovers by writing the upper nibble 0x3 several times: the writes pair off into a function-set byte with the wide bit set, then act as full 8-bit writes, and a final 0x2 write returns the interface to 4-bit mode in step.

Top module: `chr_nib_rx`

## Requirements
- R1: After reset the interface is 8 bits wide (`wide_mode`=1), `nib_phase`=0, `byte_vld`=0, and `two_line` and `big_font` are both 0.
- R2: In 8-bit mode each strobe gives `byte_q`=`bus_d` and `byte_rs`=`rs`, with `byte_vld` high in the cycle after the strobe edge, and `nib_phase` stays 0.
- R3: In 4-bit mode, a strobe with `nib_phase`=0 latches `bus_d[7:4]` as the high nibble and sets `nib_phase`=1. It emits no byte.
- R4: In 4-bit mode, a strobe with `nib_phase`=1 emits `byte_q`={latched nibble, `bus_d[7:4]`}, with `byte_rs` taken from this second write, and clears `nib_phase`.
- R5: A completed byte with `rs`=0 and bits 7:5 = 001 is a function set. It raises `is_fset` together with `byte_vld`, and `wide_mode` takes bit 4 (1 = 8-bit, 0 = 4-bit) from the following cycle on.
- R6: On a function set, `two_line` takes bit 3 and `big_font` takes bit 2 of the byte. Other bytes leave both unchanged.
- R7: A completed byte with `rs`=0 and bit 7 set raises `is_addr` together with `byte_vld`. Bits 6:0 of `byte_q` carry the address.
- R8: A latched high nibble is kept through any number of idle cycles. It pairs with the next nibble written, whatever the host intended.
- R9: A byte with `rs`=1 is data. It raises neither `is_fset` nor `is_addr`, and it changes neither the width nor `two_line`/`big_font`.
- R10: `byte_vld`, `is_fset` and `is_addr` are high only in the cycle after a strobe edge that completed a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| rs | input | 1 | Register select: 0 command, 1 data |
| bus_d | input | 8 | Data bus; bits 7:4 carry the nibble in 4-bit mode |
| byte_vld | output | 1 | One-cycle pulse with each completed byte |
| byte_rs | output | 1 | Register select of the completed byte |
| byte_q | output | 8 | Completed byte |
| is_fset | output | 1 | Completed byte is a function-set command |
| is_addr | output | 1 | Completed byte is a set-address command |
| wide_mode | output | 1 | 1 = 8-bit interface, 0 = 4-bit interface |
| nib_phase | output | 1 | 1 when a high nibble is latched |
| two_line | output | 1 | Line-count bit from the last function set |
| big_font | output | 1 | Font bit from the last function set |

## Verification
Plain 8-bit data and command writes check the byte path and the flags, with no nibble logic involved. Paired 4-bit writes with idle gaps between the halves show that the phase holds, and a data byte that looks like a function set shows that `rs` gates the decode. A host restart after a lone high nibble, followed by the 0x3, 0x3, 0x3, 0x2 recovery, shows that the stray half is absorbed and that the width returns to step. A long random stream of strobes, select values and bus values, including back-to-back strobes, is checked against a queue-based model on every clock.

// File: rtl/chr_nib_rx.sv
module chr_nib_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic       rs,
  input  logic [7:0] bus_d,
  output logic       byte_vld,
  output logic       byte_rs,
  output logic [7:0] byte_q,
  output logic       is_fset,
  output logic       is_addr,
  output logic       wide_mode,
  output logic       nib_phase,
  output logic       two_line,
  output logic       big_font
);
  logic [3:0] hi_q;
  logic [7:0] full;
  logic       cmd_fset, cmd_addr, completes;

  assign full      = wide_mode ? bus_d : {hi_q, bus_d[7:4]};
  assign cmd_fset  = !rs && (full[7:5] == 3'b001);
  assign cmd_addr  = !rs && full[7];
  assign completes = wr_stb && (wide_mode || nib_phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q      <= '0;
      byte_q    <= '0;
      byte_rs   <= 1'b0;
      byte_vld  <= 1'b0;
      is_fset   <= 1'b0;
      is_addr   <= 1'b0;
      wide_mode <= 1'b1;
      nib_phase <= 1'b0;
      two_line  <= 1'b0;
      big_font  <= 1'b0;
    end else begin
      byte_vld <= completes;
      is_fset  <= completes && cmd_fset;
      is_addr  <= completes && cmd_addr;
      if (completes) begin
        byte_q    <= full;
        byte_rs   <= rs;
        nib_phase <= 1'b0;
        if (cmd_fset) begin
          wide_mode <= full[4];
          two_line  <= full[3];
          big_font  <= full[2];
        end
      end else if (wr_stb) begin
        hi_q      <= bus_d[7:4];
        nib_phase <= 1'b1;
      end
    end
  end

  p_wide_no_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode |-> !nib_phase);
  p_first_nibble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wide_mode && !nib_phase) |=> (nib_phase && !byte_vld));
  p_second_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && nib_phase) |=> (byte_vld && !nib_phase));
  p_fset_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && is_fset) |-> (wide_mode == byte_q[4]));
  p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && nib_phase) |=> nib_phase);
  p_data_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_rs) |-> (!is_fset && !is_addr));
  p_vld_after_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stb) |-> !byte_vld);
  p_flag_with_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fset || is_addr) |-> byte_vld);
endmodule

// File: tb/chr_nib_rx_tb_top.sv
module chr_nib_rx_tb_top;
  logic clk = 0, rst_n = 0, wr_stb = 0, rs = 0;
  logic [7:0] bus_d = 0;
  logic byte_vld, byte_rs, is_fset, is_addr, wide_mode, nib_phase, two_line, big_font;
  logic [7:0] byte_q;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  chr_nib_rx dut_i (.clk, .rst_n, .wr_stb, .rs, .bus_d, .byte_vld, .byte_rs, .byte_q,
                    .is_fset, .is_addr, .wide_mode, .nib_phase, .two_line, .big_font);

  int q_nib[$];
  int m_wide = 1, m_two = 0, m_big = 0, m_vld = 0, m_rs = 0, m_byte = 0, m_fs = 0, m_ad = 0;

  task automatic emit(int b, int r);
    m_vld = 1; m_rs = r; m_byte = b;
    m_fs = (r == 0) && ((b >> 5) == 1);
    m_ad = (r == 0) && (b >= 128);
    if (m_fs) begin
      if (((b >> 4) & 1) != m_wide) q_nib.delete();
      m_wide = (b >> 4) & 1; m_two = (b >> 3) & 1; m_big = (b >> 2) & 1;
    end
  endtask

  always @(posedge clk) begin
    m_vld = 0; m_fs = 0; m_ad = 0;
    if (!rst_n) begin
      q_nib.delete(); m_wide = 1; m_two = 0; m_big = 0;
    end else if (wr_stb) begin
      if (m_wide) emit(int'(bus_d), int'(rs));
      else begin
        q_nib.push_back(int'(bus_d) >> 4);
        if (q_nib.size() == 2) begin
          int b;
          b = q_nib[0] * 16 + q_nib[1];
          q_nib.delete();
          emit(b, int'(rs));
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R10 byte_vld", byte_vld, m_vld);
    chk("R3 nib_phase", nib_phase, q_nib.size());
    chk("R5 wide_mode", wide_mode, m_wide);
    chk("R6 two_line", two_line, m_two);
    chk("R6 big_font", big_font, m_big);
    chk("R5 is_fset", is_fset, m_fs);
    chk("R7 is_addr", is_addr, m_ad);
    if (m_vld) begin
      chk("R4 byte_q", byte_q, m_byte);
      chk("R2 byte_rs", byte_rs, m_rs);
    end
  end

  task automatic wr(int d, bit r = 0, int gap = 0);
    @(negedge clk); wr_stb = 1; rs = r; bus_d = 8'(d);
    @(negedge clk); wr_stb = 0; bus_d = 8'h00;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset wide", wide_mode, 1);
    chk("R1 reset phase", nib_phase, 0);
    chk("R1 reset vld", byte_vld, 0);
    chk("R1 reset lines/font", {two_line, big_font}, 0);
    // R2 8-bit data and commands
    wr(8'hA5, 1); wr(8'h38, 1); wr(8'h5A, 0);
    wr(8'h8F, 0);                 // R7 address command
    wr(8'h3C, 0);                 // R5/R6 fset stays 8-bit
    chk("R6 two_line set", two_line, 1);
    wr(8'h20, 0);                 // R5 go to 4-bit
    chk("R5 now 4-bit", wide_mode, 0);
    wr(8'h20, 0, 3); wr(8'h80, 0);  // 0x28 with idle gap (R8)
    wr(8'h30, 1); wr(8'h80, 1);     // R9 data 0x38
    chk("R9 still 4-bit", wide_mode, 0);
    wr(8'hC0, 0); wr(8'h50, 0);     // R7 address 0xC5
    // R8 desync: stray high nibble, then host restart
    wr(8'h80, 0, 5);
    chk("R8 phase held", nib_phase, 1);
    wr(8'h30, 0); wr(8'h30, 0); wr(8'h30, 0);
    chk("R8 back to 8-bit", wide_mode, 1);
    wr(8'h20, 0);
    chk("R8 4-bit in step", {wide_mode, nib_phase}, 0);
    wr(8'h20, 0); wr(8'h80, 0);
    chk("R8 lines after recovery", two_line, 1);
    // random stream, back-to-back strobes included
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_stb = ($urandom % 3) != 0; rs = $urandom % 2; bus_d = 8'($urandom);
    end
    @(negedge clk); wr_stb = 0;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule